// File: doc/BRIEF.md
# Triggered Four-Channel Capture Buffer

This block records internal signals of a pulsed system into four parallel sample memories, so that a host can read one complete pulse afterwards. Each of the four channels has its own source-select register. That register picks one signal by number from a flat bus of internal signals. The bus carries signals such as the converter inputs and a test pattern generator.

The host sets up the selects and the set of channels it wants. It then arms the block. Once armed, the block waits for the pulse trigger. From the first 1 MHz strobe after the trigger, every enabled channel stores one 18-bit sample per strobe at consecutive addresses. All enabled channels store on the same strobes. The capture stops when the memories are full, and the block reports completion.

If no trigger comes within a programmable number of strobes, the block gives up and reports a timeout. While a capture is pending or running, host reads and select changes are refused.

Top module: `cap_buf4`

## Requirements
- R1: After reset, `done`, `timeout`, `busy` and `rd_valid` are all 0.
- R2: A pulse on `sel_wr` while not busy loads `sel_code` into the select register of channel `sel_ch`. Code n (0 to NSRC-1) selects bits `src_bus[n*W +: W]`. Codes of NSRC or more select a constant 0.
- R3: A pulse on `arm` while idle clears `done` and `timeout` at the next edge, and `busy` is 1 from that edge. At the same edge the block latches `chan_mask` and `to_lim`.
- R4: The first strobe in a cycle after the trigger cycle stores sample 0. The k-th strobe after that stores sample k-1 at address k-1 of every channel enabled in the latched mask. Each stored sample is the value of the channel's selected source in the strobe cycle.
- R5: A channel whose bit in the latched mask is 0 keeps its previous memory contents through a capture.
- R6: At the edge of the DEPTH-th captured strobe, `done` becomes 1, `timeout` stays 0 and `busy` drops to 0. `done` and `busy` are never both 1.
- R7: With `to_lim` = L > 0, the block times out if L strobes arrive while waiting and no trigger comes. At the edge of the L-th strobe, `done` and `timeout` become 1 and `busy` becomes 0. A trigger in the same cycle as the L-th strobe wins, and the capture proceeds. With L = 0 the block never times out.
- R8: A read with `rd_en`, `rd_ch` and `rd_addr` while not busy returns the stored word on `rd_data`, with `rd_valid` = 1, one cycle later. A read issued while busy gives `rd_valid` = 0.
- R9: While busy, `sel_wr` has no effect. While a capture is running, `arm` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_bus | input | NSRC*W | Flattened internal signals, source n at bits n*W +: W |
| sel_wr | input | 1 | Write strobe for a channel select register |
| sel_ch | input | CHW | Channel whose select register is written |
| sel_code | input | SELW | Source number to store |
| chan_mask | input | NCH | Channels to capture, latched on arm |
| to_lim | input | TOW | Trigger timeout in strobes, 0 disables, latched on arm |
| arm | input | 1 | Arm request pulse |
| trig | input | 1 | Pulse trigger |
| tick | input | 1 | 1 MHz sample strobe, one clock wide |
| rd_en | input | 1 | Host read request |
| rd_ch | input | CHW | Channel to read |
| rd_addr | input | AW | Sample address to read |
| rd_data | output | W | Read word, valid one cycle after the request |
| rd_valid | output | 1 | Read accepted and data present |
| busy | output | 1 | Waiting for the trigger or capturing |
| done | output | 1 | Last arm ended, by capture or by timeout |
| timeout | output | 1 | Last arm ended without a trigger |

## Verification
The status results (`busy`, `done`, `timeout`) are due at the clock edge of the strobe that causes them. That means the arm edge, the DEPTH-th captured strobe, or the L-th waiting strobe. The bench drives every strobe itself and counts strobes, so it knows exactly which cycle carries the deciding one. It samples the flags in that cycle, before the edge, to see the old value. It samples them again in the next cycle to see the new value. Read data is due one cycle after the request, and the bench samples it in the next low clock phase. Expected samples come from the bench's own formula for each source at each strobe number, counted from the trigger.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } cap_state_e;
endpackage

// File: rtl/cap_srcmux.sv
module cap_srcmux #(
  parameter int W    = 18,
  parameter int NSRC = 24,
  parameter int SELW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SELW-1:0]   wr_code,
  input  logic [NSRC*W-1:0] src_bus,
  output logic [W-1:0]      sample
);
  logic [SELW-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (wr_en) sel_q <= wr_code;
  end

  always_comb begin
    sample = '0;
    for (int s = 0; s < NSRC; s++) begin
      if ({1'b0, sel_q} == (SELW+1)'(s)) sample = src_bus[s*W +: W];
    end
  end

  // R2
  sel_upd_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_q) |-> $past(wr_en));
endmodule

// File: rtl/cap_ram.sv
module cap_ram #(
  parameter int W     = 18,
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cap_seq.sv
module cap_seq
  import cap_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DEPTH = 2048,
  parameter int AW    = 11,
  parameter int TOW   = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           arm,
  input  logic           trig,
  input  logic           tick,
  input  logic [NCH-1:0] chan_mask,
  input  logic [TOW-1:0] to_lim,
  output logic           busy,
  output logic           done,
  output logic           timeout,
  output logic [NCH-1:0] wr_en,
  output logic [AW-1:0]  wr_addr
);
  cap_state_e     st;
  logic [TOW-1:0] wcnt, lim_q;
  logic [NCH-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; done <= 1'b0; timeout <= 1'b0;
      wr_addr <= '0; wcnt <= '0; lim_q <= '0; mask_q <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_WAIT: begin
          if (arm) begin
            st <= ST_WAIT; done <= 1'b0; timeout <= 1'b0;
            wcnt <= '0; lim_q <= to_lim; mask_q <= chan_mask; wr_addr <= '0;
          end else if (st == ST_WAIT) begin
            if (trig) begin
              st <= ST_RUN; wr_addr <= '0;
            end else if (tick) begin
              if (lim_q != '0 && wcnt == lim_q - TOW'(1)) begin
                st <= ST_IDLE; done <= 1'b1; timeout <= 1'b1;
              end else begin
                wcnt <= wcnt + TOW'(1);
              end
            end
          end
        end
        ST_RUN: begin
          if (tick) begin
            if (wr_addr == AW'(DEPTH-1)) begin
              st <= ST_IDLE; done <= 1'b1;
            end else begin
              wr_addr <= wr_addr + AW'(1);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (st != ST_IDLE);
  assign wr_en = (st == ST_RUN && tick) ? mask_q : '0;

  // R6
  busy_done_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  // R6
  end_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R3
  arm_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(arm));
  // R7
  to_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> $past(tick) && !$past(trig));
  // R7
  to_done_chk: assert property (@(posedge clk) disable iff (rst)
    timeout |-> done);
endmodule

// File: rtl/cap_buf4.sv
module cap_buf4 #(
  parameter int NCH   = 4,
  parameter int DEPTH = 2048,
  parameter int W     = 18,
  parameter int NSRC  = 24,
  parameter int TOW   = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int SELW = $clog2(NSRC),
  localparam int CHW  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC*W-1:0] src_bus,
  input  logic              sel_wr,
  input  logic [CHW-1:0]    sel_ch,
  input  logic [SELW-1:0]   sel_code,
  input  logic [NCH-1:0]    chan_mask,
  input  logic [TOW-1:0]    to_lim,
  input  logic              arm,
  input  logic              trig,
  input  logic              tick,
  input  logic              rd_en,
  input  logic [CHW-1:0]    rd_ch,
  input  logic [AW-1:0]     rd_addr,
  output logic [W-1:0]      rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              done,
  output logic              timeout
);
  logic [NCH-1:0] wr_en;
  logic [AW-1:0]  wr_addr;
  logic [W-1:0]   smp [NCH];
  logic [W-1:0]   rq  [NCH];
  logic [CHW-1:0] rd_ch_q;

  cap_seq #(.NCH(NCH), .DEPTH(DEPTH), .AW(AW), .TOW(TOW)) u_seq (
    .clk, .rst, .arm, .trig, .tick, .chan_mask, .to_lim,
    .busy, .done, .timeout, .wr_en, .wr_addr
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel_we;
    assign sel_we = sel_wr && !busy && (sel_ch == CHW'(g));

    cap_srcmux #(.W(W), .NSRC(NSRC), .SELW(SELW)) u_mux (
      .clk, .rst, .wr_en(sel_we), .wr_code(sel_code),
      .src_bus, .sample(smp[g])
    );

    cap_ram #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_ram (
      .clk, .we(wr_en[g]), .waddr(wr_addr), .wdata(smp[g]),
      .raddr(rd_addr), .rdata(rq[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0; rd_ch_q <= '0;
    end else begin
      rd_valid <= rd_en && !busy;
      rd_ch_q  <= rd_ch;
    end
  end

  assign rd_data = rq[rd_ch_q];

  // R8
  rd_ok_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en) && !$past(busy));
endmodule

// File: tb/tb_cap_buf4.sv
`timescale 1ns/1ps
module tb_cap_buf4;
  localparam int NCH = 4, DEPTH = 2048, W = 18, NSRC = 24, TOW = 16;
  localparam int AW = $clog2(DEPTH), SELW = $clog2(NSRC), CHW = $clog2(NCH);
  localparam int TPER = 5;

  logic clk = 0, rst = 1;
  logic [NSRC*W-1:0] src_bus = '0;
  logic sel_wr = 0; logic [CHW-1:0] sel_ch = '0; logic [SELW-1:0] sel_code = '0;
  logic [NCH-1:0] chan_mask = '0; logic [TOW-1:0] to_lim = '0;
  logic arm = 0, trig = 0, tick = 0, rd_en = 0;
  logic [CHW-1:0] rd_ch = '0; logic [AW-1:0] rd_addr = '0;
  logic [W-1:0] rd_data; logic rd_valid, busy, done, timeout;

  cap_buf4 #(.NCH(NCH), .DEPTH(DEPTH), .W(W), .NSRC(NSRC), .TOW(TOW)) dut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, nt = 0, armnt = 0, base = 0;
  int selm [NCH];
  logic [W-1:0] expm [NCH][DEPTH];

  function automatic logic [W-1:0] fval(int s, int n);
    return W'((s * 1237 + n * 29 + 5) ^ (n << 7));
  endfunction

  function automatic logic [W-1:0] srcv(int code, int n);
    return (code >= NSRC) ? '0 : fval(code, n);
  endfunction

  always @(negedge clk) begin
    cyc++;
    tick = (cyc % TPER == 0);
    for (int s = 0; s < NSRC; s++) src_bus[s*W +: W] = fval(s, nt);
    if (tick) nt++;
  end

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic set_sel(int ch, int code);
    @(negedge clk); sel_wr = 1; sel_ch = CHW'(ch); sel_code = SELW'(code);
    @(negedge clk); sel_wr = 0;
  endtask

  task automatic do_arm(logic [NCH-1:0] m, int lim);
    @(negedge clk); #1; chan_mask = m; to_lim = TOW'(lim); arm = 1; armnt = nt;
    @(negedge clk); arm = 0; #1;
    chk(busy === 1'b1, "R3 busy after arm", busy, 1);
    chk(done === 1'b0 && timeout === 1'b0, "R3 flags cleared", {done, timeout}, 0);
  endtask

  task automatic do_trig();
    @(negedge clk); #1;
    while (tick) begin @(negedge clk); #1; end
    trig = 1; base = nt;
    @(negedge clk); trig = 0;
  endtask

  task automatic wait_nt(int target);
    forever begin
      @(negedge clk); #1;
      if (nt >= target) break;
    end
  endtask

  task automatic rd(int ch, int a, output logic [W-1:0] d, output logic v);
    @(negedge clk); rd_en = 1; rd_ch = CHW'(ch); rd_addr = AW'(a);
    @(negedge clk); rd_en = 0; #1; d = rd_data; v = rd_valid;
  endtask

  task automatic end_capture(logic [NCH-1:0] m);
    wait_nt(base + DEPTH);
    chk(done === 1'b0 && busy === 1'b1, "R6 still running before last strobe", done, 0);
    @(negedge clk); #1;
    chk(done === 1'b1 && timeout === 1'b0 && busy === 1'b0, "R6 done at last strobe",
        {done, timeout, busy}, 3'b100);
    for (int c = 0; c < NCH; c++)
      if (m[c]) for (int i = 0; i < DEPTH; i++) expm[c][i] = srcv(selm[c], base + i);
  endtask

  task automatic read_all(string req);
    logic [W-1:0] d; logic v;
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < DEPTH; i++) begin
        rd(c, i, d, v);
        chk(v === 1'b1 && d === expm[c][i], req, int'(d), int'(expm[c][i]));
      end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 190000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] d; logic v;
    void'($urandom(32'd77));
    for (int c = 0; c < NCH; c++) begin
      selm[c] = 0;
      for (int i = 0; i < DEPTH; i++) expm[c][i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 0; #1;
    // R1
    chk(done === 0 && timeout === 0 && busy === 0 && rd_valid === 0, "R1 reset state",
        {done, timeout, busy, rd_valid}, 0);

    // Capture A: fixed selects, one out of range (R2), all channels (R4)
    set_sel(0, 0); selm[0] = 0;
    set_sel(1, 5); selm[1] = 5;
    set_sel(2, 23); selm[2] = 23;
    set_sel(3, 30); selm[3] = 30;
    do_arm(4'b1111, 0);
    set_sel(0, 7); // R9: ignored while waiting
    repeat (13) @(negedge clk);
    do_trig();
    repeat (40) @(negedge clk);
    rd(1, 0, d, v);
    chk(v === 1'b0, "R8 read refused while busy", v, 0);
    @(negedge clk); arm = 1; @(negedge clk); arm = 0; // R9: arm ignored in capture
    end_capture(4'b1111);
    read_all("R4 R2 R9 capture A data");

    // Capture B: random selects, half the channels (R5)
    for (int c = 0; c < NCH; c++) begin
      int code = int'($urandom % 32);
      set_sel(c, code); selm[c] = code;
    end
    do_arm(4'b0101, 0);
    repeat (int'($urandom % 30) + 3) @(negedge clk);
    do_trig();
    end_capture(4'b0101);
    read_all("R5 R4 capture B data");

    // Timeout with L=3 (R7)
    do_arm(4'b1111, 3);
    wait_nt(armnt + 3);
    chk(done === 1'b0 && busy === 1'b1, "R7 no timeout before limit", done, 0);
    @(negedge clk); #1;
    chk(done === 1'b1 && timeout === 1'b1 && busy === 1'b0, "R7 timeout at limit",
        {done, timeout, busy}, 3'b110);

    // Re-arm clears flags (R3); trigger on limit strobe wins (R7)
    set_sel(3, 11); selm[3] = 11;
    do_arm(4'b1000, 2);
    wait_nt(armnt + 2);
    trig = 1; base = nt;
    @(negedge clk); trig = 0; #1;
    chk(timeout === 1'b0 && busy === 1'b1, "R7 trigger wins on limit strobe", timeout, 0);
    end_capture(4'b1000);
    for (int k = 0; k < 16; k++) begin
      int a = int'($urandom % DEPTH);
      rd(3, a, d, v);
      chk(v === 1'b1 && d === expm[3][a], "R8 R4 capture C data", int'(d), int'(expm[3][a]));
      rd(0, a, d, v);
      chk(v === 1'b1 && d === expm[0][a], "R5 capture C untouched", int'(d), int'(expm[0][a]));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule